// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog peripheral on a simple register bus with a word address, a write strobe, write data and combinational read data. Software picks a timeout as a power-of-two cycle count, turns the timer on, and from then on must write a fixed key value to a restart register before the down-counter reaches zero. Turning the timer on cannot be undone by software. Only the block's own asynchronous reset stops it.

When the counter runs out, the block takes one of two actions, chosen by a mode bit. In direct mode it drives a system reset pulse of fixed width. In warning mode it first raises an interrupt and reloads the counter. If the next countdown also expires without a valid restart, it drives the reset pulse. Software can read the live count at any time. The first countdown after enabling uses its own period field. Every later reload uses the main period field.

Register map (byte offsets): 0x0 control, 0x4 period select, 0x8 live count (read only), 0xC restart key (write only). The exponent base is the parameter `BASE_EXP`, which defaults to 16.

Top module: `wdog_timer`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `sys_rst_o` is 0.
- R2: In the control register, bit 0 is enable and bit 1 is mode. Mode 0 is direct reset and mode 1 is interrupt first. Writing bit 0 = 1 while disabled loads the counter with 2^(BASE_EXP+s)-1, where s is bits 7:4 of the period register. The count then falls by one per cycle.
- R3: A write of exactly 0x76 to offset 0xC while enabled reloads the counter with 2^(BASE_EXP+p)-1, where p is bits 3:0 of the period register.
- R4: A write of any other value to offset 0xC does not reload the counter.
- R5: Once set, the enable bit stays set whatever software writes. While the block is disabled the count holds.
- R6: In mode 0, an expiry drives `sys_rst_o` high for exactly 8 cycles.
- R7: In mode 1, the first expiry sets `irq_o` and reloads the counter. A further expiry with `irq_o` still set drives the reset pulse. A valid restart clears `irq_o`.
- R8: A write to the period register does not change the current countdown. The new value takes effect at the next reload.
- R9: Reserved bits read 0. Offset 0xC and unmapped offsets read 0. Offset 0x8 returns the live count.
- R10: Expiries occur exactly 2^(BASE_EXP+p) cycles after a reload. When the count is 0, the next edge is an expiry, which also reloads the counter. A valid restart on that same edge wins and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Expiry warning interrupt (mode 1) |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with `BASE_EXP` = 2, so periods run from 4 to 131072 cycles. Full expiry chains therefore fit in a short run: warning, then reset, pulse width, and retriggered pulses when the period is shorter than the pulse. The shortest periods also make restarts land on the expiry edge and period writes land mid-countdown, so those cases occur often in the random phase. A separate directed run measures exact reload-to-expiry intervals for small exponents.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned PULSE_LEN = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_RANGE = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_KICK  = 4'hC;

  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_0076;

  typedef struct packed {
    logic mode;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  output ctrl_t             ctrl_o,
  output logic [SEL_W-1:0]  per_o,
  output logic [SEL_W-1:0]  init_o,
  output logic              start_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t            ctrl_q;
  logic [SEL_W-1:0] per_q, init_q;
  logic             wr_ctrl, wr_range;

  assign wr_ctrl  = we_i && (addr_i == OFF_CTRL);
  assign wr_range = we_i && (addr_i == OFF_RANGE);
  assign start_o  = wr_ctrl && wdata_i[0] && !ctrl_q.en;
  assign kick_o   = we_i && (addr_i == OFF_KICK) && (wdata_i == KICK_KEY) && ctrl_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      per_q  <= '0;
      init_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= ctrl_q.en | wdata_i[0];  // sticky
        ctrl_q.mode <= wdata_i[1];
      end
      if (wr_range) begin
        per_q  <= wdata_i[SEL_W-1:0];
        init_q <= wdata_i[2*SEL_W-1:SEL_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL:  rdata_o = DATA_W'(ctrl_q);
      OFF_RANGE: rdata_o = DATA_W'({init_q, per_q});
      OFF_COUNT: rdata_o = count_i;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign per_o  = per_q;
  assign init_o = init_q;

  assert_sticky_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.en |=> ctrl_q.en);
  assert_start_sets_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> ctrl_q.en);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 16,
  localparam int unsigned CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             kick_i,
  input  logic [SEL_W-1:0] per_i,
  input  logic [SEL_W-1:0] init_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] reload_val(input logic [SEL_W-1:0] sel);
    logic [CNT_W:0] one_hot;
    one_hot = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + int'(sel));
    return CNT_W'(one_hot - 1'b1);
  endfunction

  assign expire_o = en_i && !kick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= reload_val(init_i);
    else if (en_i) begin
      if (kick_i || expire_o)  cnt_q <= reload_val(per_i);
      else                     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count_o = cnt_q;

  assert_count_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !kick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_hold_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> $stable(cnt_q));
  assert_reload_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q != '0));
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic kick_i,
  input  logic mode_i,
  output logic irq_o,
  output logic sys_rst_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic          irq_q;
  logic [PW-1:0] pulse_q;
  logic          fire;

  // mode 0: reset at once; mode 1: reset only on expiry with warning pending
  assign fire = expire_i && (!mode_i || irq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (kick_i)                            irq_q <= 1'b0;
      else if (expire_i && mode_i && !irq_q) irq_q <= 1'b1;

      if (fire)               pulse_q <= PW'(PULSE_LEN);
      else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = (pulse_q != '0);

  assert_direct_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !mode_i) |=> sys_rst_o);
  assert_pulse_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q == PW'(1) && !fire) |=> !sys_rst_o);
  assert_warn_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && mode_i && !irq_q && !sys_rst_o) |=> (irq_o && !sys_rst_o));
  assert_kick_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !irq_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        sys_rst_o
);
  localparam int unsigned CNT_W = BASE_EXP + (1 << SEL_W) - 1;

  ctrl_t            ctrl;
  logic [SEL_W-1:0] per, init;
  logic             start, kick, expire;
  logic [CNT_W-1:0] count;

  wdog_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .count_i (DATA_W'(count)),
    .ctrl_o  (ctrl),
    .per_o   (per),
    .init_o  (init),
    .start_o (start),
    .kick_o  (kick),
    .rdata_o (rdata_o)
  );

  wdog_counter #(.BASE_EXP(BASE_EXP)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl.en),
    .start_i  (start),
    .kick_i   (kick),
    .per_i    (per),
    .init_i   (init),
    .count_o  (count),
    .expire_o (expire)
  );

  wdog_resp u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .kick_i    (kick),
    .mode_i    (ctrl.mode),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o)
  );

  assert_bad_key_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_KICK && wdata_i != KICK_KEY && ctrl.en && count != '0)
    |=> (count == $past(count) - 1'b1));
  assert_no_irq_direct_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.en) |-> (!irq_o && !sys_rst_o));
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int unsigned B = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sys_rst;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_timer #(.BASE_EXP(B)) u_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .sys_rst_o(sys_rst)
  );

  // reference model from the requirements
  logic        m_en, m_mode, m_irq;
  logic [3:0]  m_per, m_init;
  logic [31:0] m_cnt;
  int          m_pulse;

  function automatic logic [31:0] lv(input logic [3:0] s);
    return (32'd1 << (B + s)) - 1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      4'h0: return {30'd0, m_mode, m_en};
      4'h4: return {24'd0, m_init, m_per};
      4'h8: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= 0; m_mode <= 0; m_irq <= 0; m_per <= 0; m_init <= 0; m_cnt <= 0; m_pulse <= 0;
    end else begin
      logic st, kk, ex;
      st = we && addr == 4'h0 && wdata[0] && !m_en;
      kk = we && addr == 4'hC && wdata == 32'h76 && m_en;
      ex = m_en && !kk && m_cnt == 0;
      if (we && addr == 4'h0) begin m_en <= m_en | wdata[0]; m_mode <= wdata[1]; end
      if (we && addr == 4'h4) begin m_per <= wdata[3:0]; m_init <= wdata[7:4]; end
      if (st) m_cnt <= lv(m_init);
      else if (m_en) m_cnt <= (kk || ex) ? lv(m_per) : m_cnt - 1;
      if (kk) m_irq <= 0;
      else if (ex && m_mode && !m_irq) m_irq <= 1;
      if (ex && (!m_mode || m_irq)) m_pulse <= 8;
      else if (m_pulse != 0) m_pulse <= m_pulse - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 sys_rst", {31'd0, sys_rst}, {31'd0, m_pulse != 0});
      chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R9 rdata", rdata, exp_rd(addr));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(); we = 1'b1; addr = a; wdata = d;
    step(); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_reset();
    step(); rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1 reset state
    foreach (d[i]) ;
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h4, d); chk("R1 range", d, 0);
    rd(4'h8, d); chk("R1 count", d, 0);
    chk("R1 outs", {30'd0, irq, sys_rst}, 0);
    // R5 hold while disabled, R9 reserved bits
    wr(4'h4, 32'hFFFF_FF31);            // init=3, per=1
    rd(4'h4, d); chk("R9 reserved range", d, 32'h31);
    wr(4'hC, 32'h76);                   // ignored while disabled
    repeat (4) step();
    rd(4'h8, d); chk("R5 hold disabled", d, 0);
    // R2 enable loads init period
    wr(4'h0, 32'hFFFF_FFFD);            // en=1, mode=0, reserved set
    rd(4'h0, d); chk("R9 reserved ctrl", d, 32'h1);
    rd(4'h8, d); chk("R2 init load", d, lv(3));
    repeat (5) step();
    rd(4'h8, d); chk("R2 count down", d, lv(3) - 5);
    // R5 sticky
    wr(4'h0, 32'h0);
    rd(4'h0, d); chk("R5 sticky", d, 32'h1);
    // R4 bad key
    rd(4'h8, d); n = d;
    wr(4'hC, 32'h77);
    rd(4'h8, d); chk("R4 bad key", d, n - 2);
    wr(4'hC, 32'h176);
    rd(4'h8, d); chk("R4 bad upper", d, n - 4);
    rd(4'hC, d); chk("R9 kick reads 0", d, 0);
    rd(4'h2, d); chk("R9 unmapped", d, 0);
    // R3 valid kick
    wr(4'hC, 32'h76);
    rd(4'h8, d); chk("R3 reload", d, lv(1));
    // R10 period 2^(B+1) = 8 cycles to expiry
    n = 0;
    do begin step(); n++; end while (!sys_rst && n < 100);
    chk("R10 period", n, 8);
    // R8 range write mid-countdown
    wr(4'h4, 32'h33);                   // per=3
    rd(4'h8, d); n = d;
    chk("R8 mid unaffected", d, lv(1) - 2);
    repeat (n + 1) step();
    rd(4'h8, d); chk("R8 next reload", d, lv(3));
    // R6 pulse width with a long period
    do_reset();
    wr(4'h4, 32'h44);
    wr(4'h0, 32'h1);
    n = 0;
    while (!sys_rst) step();
    while (sys_rst) begin step(); n++; end
    chk("R6 width", n, 8);
    // R7 interrupt mode
    do_reset();
    wr(4'h4, 32'h22);
    wr(4'h0, 32'h3);
    n = 0;
    do begin step(); n++; end while (!irq && n < 100);
    chk("R7 warn time", n, 16);
    chk("R7 no reset on warn", sys_rst, 0);
    wr(4'hC, 32'h76);
    chk("R7 kick clears", irq, 0);
    n = 0;
    do begin step(); n++; end while (!irq && n < 100);
    chk("R7 warn again", n, 16);
    n = 0;
    do begin step(); n++; end while (!sys_rst && n < 100);
    chk("R7 reset after warn", n, 16);
    chk("R7 irq held", irq, 1);
    // random phase, model-checked
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step();
      if (r < 55) begin we = 1'b0; addr = 4'($urandom_range(0, 15)); end
      else if (r < 80) begin we = 1'b1; addr = 4'hC; wdata = ($urandom_range(0, 9) < 8) ? 32'h76 : $urandom; end
      else if (r < 90) begin we = 1'b1; addr = 4'h4; wdata = {$urandom} & 32'hFFFF_FF33; end
      else if (r < 96) begin we = 1'b1; addr = 4'h0; wdata = $urandom; end
      else begin we = 1'b1; addr = 4'($urandom); wdata = $urandom; end
      if (i % 1000 == 999) begin step(); we = 1'b0; do_reset(); end
    end
    step(); we = 1'b0;
    step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule